// File: doc/BRIEF.md
# Ping-Pong Circular Buffer Chunk Streamer

An external writer fills a circular sample buffer of `BUF_ITEMS` entries. It raises a one-cycle `wr_half` pulse each time it crosses the midpoint and a `wr_full` pulse each time it wraps past the end. This block turns those pulses into chunk descriptors, one for the part of the buffer just filled. Each descriptor gives a start index, an item count, a close flag, a flag saying which half it covers, and an 8-bit sequence number. A downstream consumer takes descriptors over a valid/ready handshake. The consumer acknowledges each half separately once it has finished reading that region.

There are three capture kinds. A continuous stream runs until it is stopped. A block capture and a triggered capture each stop after a set number of sample groups, where a sample group is one item per channel. Each half has a busy flag. If the writer comes back to a half that is still unacknowledged, the capture is torn. The block then parks in a shutdown mode until it receives a stop command. Events that arrive while the descriptor slot is stalled are held in a small per-half latch. A late or coincident pair of events is replayed in buffer order.

Top module: `ping_pong_chunker`

## Requirements
- R1: After reset `mode_o` is 0 (idle), `d_valid` is 0, and both busy flags are 0.
- R2: Mode codes are 0 idle, 1 stream, 2 block, 3 triggered, 4 rearm-pending and 5 shutdown. A half event covers items from the current start index up to `BUF_ITEMS/2`, and a full event covers items up to `BUF_ITEMS`. Afterwards the start index becomes `BUF_ITEMS/2` or 0 respectively. `d_full` is 1 for a full-event chunk and 0 for a half-event chunk.
- R3: `d_count` is the number of whole sample groups in the span multiplied by `CHANNELS`. In block and triggered modes the group count is capped at the remaining count, and the remaining count is then reduced by it.
- R4: `d_close` is 1 only in block or triggered mode, and only when the remaining group count has reached zero. A stream chunk never closes.
- R5: After a closing chunk the mode becomes idle. If the capture was triggered and `auto_rearm` is high, the mode becomes rearm-pending instead.
- R6: Emitting a chunk sets that half's busy flag, and the matching acknowledge clears it. An event whose span is not empty, arriving while that half is busy, sends the mode to shutdown and emits no chunk. A repeat event for a half whose previous event is still latched does the same.
- R7: When the start index equals the span's end, no chunk is emitted, but the start index still advances.
- R8: When both events are pending together, the full chunk is emitted first if the start index is past the midpoint. Otherwise the half chunk is emitted first.
- R9: A lone half event that arrives while the start index is past the midpoint is preceded by the processing of a missed full event.
- R10: `d_seq` is 0 for the first chunk of a capture and increases by one for each chunk emitted.
- R11: While `d_valid` is high and `d_ready` is low, the descriptor holds steady. Events that arrive meanwhile are emitted later, in order.
- R12: The start commands (`cap_stream`, `cap_block`, `cap_trig`) load `cap_pos` and `cap_len`, and are accepted only in idle or rearm-pending mode. `cap_stop` returns any mode to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stream | input | 1 | Start a continuous stream |
| cap_block | input | 1 | Start a block capture |
| cap_trig | input | 1 | Start a triggered capture |
| cap_stop | input | 1 | Stop, or leave shutdown |
| cap_pos | input | IDX_W | Writer index at capture start |
| cap_len | input | GRP_W | Sample groups for finite captures |
| auto_rearm | input | 1 | Go to rearm-pending after a triggered capture closes |
| wr_half | input | 1 | Writer crossed the midpoint |
| wr_full | input | 1 | Writer wrapped at the end |
| ack_half | input | 1 | Consumer released the lower half |
| ack_full | input | 1 | Consumer released the upper half |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Consumer accepts the descriptor |
| d_start | output | IDX_W | First item index of the chunk |
| d_count | output | IDX_W | Item count of the chunk |
| d_close | output | 1 | Last chunk of a finite capture |
| d_full | output | 1 | Chunk closes the upper half |
| d_seq | output | SEQ_W | Chunk sequence number |
| mode_o | output | 3 | Current mode code |
| busy_half | output | 1 | Lower half awaiting acknowledge |
| busy_full | output | 1 | Upper half awaiting acknowledge |

## Verification
The half and full events can land in the same cycle. That happens when the writer wraps while the previous midpoint is still latched, or when both pulses are driven together. The bench provokes this by raising both pulses at once, with the start index first below and then above the midpoint. It also sends a lone half pulse while the start index sits past the midpoint. In each case the scoreboard expects the two descriptors in buffer order, with consecutive sequence numbers and spans that meet at the midpoint or at zero.

// File: rtl/chunk_pkg.sv
package chunk_pkg;
   typedef enum logic [2:0] {
      M_IDLE   = 3'd0,
      M_STREAM = 3'd1,
      M_BLOCK  = 3'd2,
      M_TRIG   = 3'd3,
      M_REARM  = 3'd4,
      M_SHUT   = 3'd5
   } mode_e;

   localparam int unsigned HALF_IX = 0;
   localparam int unsigned FULL_IX = 1;
endpackage

// File: rtl/chunk_evt_latch.sv
module chunk_evt_latch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic [1:0] evt,
   input  logic [1:0] take,
   output logic [1:0] lat,
   output logic       dup
);
   logic [1:0] dup_v;

   for (genvar g = 0; g < 2; g++) begin : g_side
      always_ff @(posedge clk) begin
         if (!rst_n || flush) lat[g] <= 1'b0;
         else                 lat[g] <= (lat[g] & ~take[g]) | evt[g];
      end
      assign dup_v[g] = evt[g] & lat[g] & ~take[g];
   end

   assign dup = |dup_v;
endmodule

// File: rtl/chunk_order.sv
module chunk_order (
   input  logic [1:0] lat,
   input  logic       past_mid,
   output logic       go,
   output logic       sel_full,
   output logic [1:0] take
);
   always_comb begin
      go       = |lat;
      // Past the midpoint the upper half must be closed before anything else.
      sel_full = past_mid ? 1'b1 : (lat[1] & ~lat[0]);
      take[1]  = go & sel_full & lat[1];
      take[0]  = go & ~sel_full;
   end
endmodule

// File: rtl/chunk_span.sv
module chunk_span #(
   parameter int unsigned BUF_ITEMS = 64,
   parameter int unsigned CHANNELS  = 4,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned GRP_W     = 16
) (
   input  logic [IDX_W-1:0] start_pos,
   input  logic             sel_full,
   input  logic             finite,
   input  logic [GRP_W-1:0] remain,
   output logic             empty,
   output logic [IDX_W-1:0] item_cnt,
   output logic [GRP_W-1:0] remain_nx,
   output logic             close
);
   localparam int unsigned HALF  = BUF_ITEMS / 2;
   localparam logic [IDX_W-1:0] END_H = IDX_W'(HALF);
   localparam logic [IDX_W-1:0] END_F = IDX_W'(BUF_ITEMS);
   localparam int unsigned SH    = $clog2(CHANNELS);
   localparam bit          POW2  = ((1 << SH) == CHANNELS);

   logic [IDX_W-1:0] end_pos, span;
   logic [GRP_W-1:0] groups, used;

   assign end_pos = sel_full ? END_F : END_H;
   assign empty   = (start_pos == end_pos);
   assign span    = end_pos - start_pos;

   if (POW2) begin : g_shift
      assign groups = GRP_W'(span >> SH);
   end else begin : g_div
      assign groups = GRP_W'(span / IDX_W'(CHANNELS));
   end

   always_comb begin
      used      = (finite && remain < groups) ? remain : groups;
      remain_nx = finite ? remain - used : remain;
      close     = finite && (remain_nx == '0);
      item_cnt  = IDX_W'(used * GRP_W'(CHANNELS));
   end
endmodule

// File: rtl/ping_pong_chunker.sv
module ping_pong_chunker #(
   parameter int unsigned BUF_ITEMS = 64,
   parameter int unsigned CHANNELS  = 4,
   parameter int unsigned GRP_W     = 16,
   parameter int unsigned SEQ_W     = 8,
   parameter int unsigned IDX_W     = $clog2(BUF_ITEMS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_stream,
   input  logic             cap_block,
   input  logic             cap_trig,
   input  logic             cap_stop,
   input  logic [IDX_W-1:0] cap_pos,
   input  logic [GRP_W-1:0] cap_len,
   input  logic             auto_rearm,
   input  logic             wr_half,
   input  logic             wr_full,
   input  logic             ack_half,
   input  logic             ack_full,
   output logic             d_valid,
   input  logic             d_ready,
   output logic [IDX_W-1:0] d_start,
   output logic [IDX_W-1:0] d_count,
   output logic             d_close,
   output logic             d_full,
   output logic [SEQ_W-1:0] d_seq,
   output logic [2:0]       mode_o,
   output logic             busy_half,
   output logic             busy_full
);
   import chunk_pkg::*;

   localparam int unsigned HALF = BUF_ITEMS / 2;
   localparam logic [IDX_W-1:0] MID = IDX_W'(HALF);

   if (BUF_ITEMS % (2 * CHANNELS) != 0) begin : g_bad_size
      $error("BUF_ITEMS must be a multiple of 2*CHANNELS");
   end
   if (CHANNELS < 1 || SEQ_W < 1) begin : g_bad_width
      $error("CHANNELS and SEQ_W must be positive");
   end
   if (IDX_W < $clog2(BUF_ITEMS + 1)) begin : g_bad_idx
      $error("IDX_W too narrow for BUF_ITEMS");
   end

   mode_e            mode;
   logic [IDX_W-1:0] start_pos;
   logic [GRP_W-1:0] remain;
   logic [SEQ_W-1:0] seq_cnt;

   logic [1:0]       lat, take, take_g;
   logic             dup, go, sel_full;
   logic             active, finite, slot_free, step;
   logic             empty, span_close, busy_sel;
   logic [IDX_W-1:0] item_cnt;
   logic [GRP_W-1:0] remain_nx;
   logic             emit, emit_close, emit_full, torn, go_shut, idle_like;

   assign active    = (mode == M_STREAM) || (mode == M_BLOCK) || (mode == M_TRIG);
   assign finite    = (mode == M_BLOCK) || (mode == M_TRIG);
   assign idle_like = (mode == M_IDLE) || (mode == M_REARM);
   assign slot_free = !d_valid || d_ready;

   chunk_evt_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!active),
      .evt   ({wr_full, wr_half}),
      .take  (take_g),
      .lat   (lat),
      .dup   (dup)
   );

   chunk_order u_order (
      .lat      (lat),
      .past_mid (start_pos > MID),
      .go       (go),
      .sel_full (sel_full),
      .take     (take)
   );

   chunk_span #(
      .BUF_ITEMS (BUF_ITEMS),
      .CHANNELS  (CHANNELS),
      .IDX_W     (IDX_W),
      .GRP_W     (GRP_W)
   ) u_span (
      .start_pos (start_pos),
      .sel_full  (sel_full),
      .finite    (finite),
      .remain    (remain),
      .empty     (empty),
      .item_cnt  (item_cnt),
      .remain_nx (remain_nx),
      .close     (span_close)
   );

   assign step       = active && go && slot_free && !cap_stop;
   assign take_g     = take & {2{step}};
   assign busy_sel   = sel_full ? busy_full : busy_half;
   assign torn       = step && !empty && busy_sel;
   assign emit       = step && !empty && !busy_sel && !dup;
   assign emit_close = span_close;
   assign emit_full  = sel_full;
   assign go_shut    = active && !cap_stop && (torn || dup);

   // Mode, capture counters and start index
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= M_IDLE;
         start_pos <= '0;
         remain    <= '0;
         seq_cnt   <= '0;
      end else if (cap_stop) begin
         mode <= M_IDLE;
      end else if (idle_like && (cap_stream || cap_block || cap_trig)) begin
         mode      <= cap_stream ? M_STREAM : (cap_block ? M_BLOCK : M_TRIG);
         start_pos <= cap_pos;
         remain    <= cap_len;
         seq_cnt   <= '0;
      end else if (go_shut) begin
         mode <= M_SHUT;
      end else if (step) begin
         start_pos <= sel_full ? '0 : MID;
         remain    <= remain_nx;
         if (emit) begin
            seq_cnt <= seq_cnt + 1'b1;
            if (emit_close)
               mode <= (mode == M_TRIG && auto_rearm) ? M_REARM : M_IDLE;
         end
      end
   end

   // Per-half busy flags
   always_ff @(posedge clk) begin
      if (!rst_n || cap_stop || go_shut || (emit && emit_close)) begin
         busy_half <= 1'b0;
         busy_full <= 1'b0;
      end else begin
         busy_half <= (busy_half & ~ack_half) | (emit & ~emit_full);
         busy_full <= (busy_full & ~ack_full) | (emit & emit_full);
      end
   end

   // Descriptor slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_valid <= 1'b0;
         d_start <= '0;
         d_count <= '0;
         d_close <= 1'b0;
         d_full  <= 1'b0;
         d_seq   <= '0;
      end else if (emit) begin
         d_valid <= 1'b1;
         d_start <= start_pos;
         d_count <= item_cnt;
         d_close <= emit_close;
         d_full  <= emit_full;
         d_seq   <= seq_cnt;
      end else if (d_ready) begin
         d_valid <= 1'b0;
      end
   end

   assign mode_o = mode;
endmodule

// File: rtl/chunk_checker.sv
module chunk_checker #(
   parameter int unsigned BUF_ITEMS = 64,
   parameter int unsigned CHANNELS  = 4,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned SEQ_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             d_valid,
   input logic             d_ready,
   input logic [IDX_W-1:0] d_start,
   input logic [IDX_W-1:0] d_count,
   input logic [SEQ_W-1:0] d_seq,
   input logic [2:0]       mode_o,
   input logic             busy_half,
   input logic             busy_full,
   input logic             cap_stop,
   input logic             emit,
   input logic             emit_close,
   input logic             emit_full
);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid && !d_ready |=> d_valid && $stable(d_start) && $stable(d_count) && $stable(d_seq));

   p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (d_count <= IDX_W'(BUF_ITEMS)) && (d_count % IDX_W'(CHANNELS) == '0));

   p_close_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      emit && emit_close && !cap_stop |=> (mode_o == 3'd0) || (mode_o == 3'd4));

   p_busy_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      emit && !emit_close && !emit_full |=> busy_half);

   p_busy_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      emit && !emit_close && emit_full |=> busy_full);

   p_shut_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5) && !cap_stop |=> mode_o == 3'd5);

   p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stop |=> mode_o == 3'd0);
endmodule

bind ping_pong_chunker chunk_checker #(
   .BUF_ITEMS (BUF_ITEMS),
   .CHANNELS  (CHANNELS),
   .IDX_W     (IDX_W),
   .SEQ_W     (SEQ_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .d_valid    (d_valid),
   .d_ready    (d_ready),
   .d_start    (d_start),
   .d_count    (d_count),
   .d_seq      (d_seq),
   .mode_o     (mode_o),
   .busy_half  (busy_half),
   .busy_full  (busy_full),
   .cap_stop   (cap_stop),
   .emit       (emit),
   .emit_close (emit_close),
   .emit_full  (emit_full)
);

// File: tb/tb_ping_pong_chunker.sv
module tb_ping_pong_chunker;
   localparam int IDX_W = 7;
   localparam int GRP_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_stream = 0, cap_block = 0, cap_trig = 0, cap_stop = 0;
   logic [IDX_W-1:0] cap_pos = '0;
   logic [GRP_W-1:0] cap_len = '0;
   logic auto_rearm = 0, wr_half = 0, wr_full = 0, ack_half = 0, ack_full = 0;
   logic d_ready = 1'b1;
   logic d_valid, d_close, d_full, busy_half, busy_full;
   logic [IDX_W-1:0] d_start, d_count;
   logic [7:0] d_seq;
   logic [2:0] mode_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   logic [23:0] exp_q[$];

   always #10 clk = ~clk;

   ping_pong_chunker dut (
      .clk(clk), .rst_n(rst_n), .cap_stream(cap_stream), .cap_block(cap_block),
      .cap_trig(cap_trig), .cap_stop(cap_stop), .cap_pos(cap_pos), .cap_len(cap_len),
      .auto_rearm(auto_rearm), .wr_half(wr_half), .wr_full(wr_full),
      .ack_half(ack_half), .ack_full(ack_full), .d_valid(d_valid), .d_ready(d_ready),
      .d_start(d_start), .d_count(d_count), .d_close(d_close), .d_full(d_full),
      .d_seq(d_seq), .mode_o(mode_o), .busy_half(busy_half), .busy_full(busy_full)
   );

   function automatic logic [23:0] mk(int s, int c, bit cl, bit fu, int sq);
      return {7'(s), 7'(c), cl, fu, 8'(sq)};
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Scoreboard monitor: compare each accepted descriptor with the queue head
   always @(negedge clk) begin
      #1;
      if (rst_n && d_valid && d_ready) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected chunk: actual %h expected none",
                     {d_start, d_count, d_close, d_full, d_seq});
         end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            if ({d_start, d_count, d_close, d_full, d_seq} != e) begin
               n_fail++;
               $display("FAIL R2/R3/R4/R8/R9/R10 chunk: actual %h expected %h",
                        {d_start, d_count, d_close, d_full, d_seq}, e);
            end
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start(int kind, int pos, int len);
      @(negedge clk);
      cap_pos = 7'(pos);
      cap_len = 16'(len);
      cap_stream = (kind == 1);
      cap_block  = (kind == 2);
      cap_trig   = (kind == 3);
      @(negedge clk);
      cap_stream = 0; cap_block = 0; cap_trig = 0;
   endtask

   task automatic stop();
      @(negedge clk); cap_stop = 1;
      @(negedge clk); cap_stop = 0;
   endtask

   task automatic evt(bit h, bit f);
      @(negedge clk); wr_half = h; wr_full = f;
      @(negedge clk); wr_half = 0; wr_full = 0;
   endtask

   task automatic ack(bit h, bit f);
      @(negedge clk); ack_half = h; ack_full = f;
      @(negedge clk); ack_half = 0; ack_full = 0;
   endtask

   task automatic drain(string req);
      for (int i = 0; i < 30 && exp_q.size() != 0; i++) @(negedge clk);
      cyc(3);
      chk({req, " chunks outstanding"}, exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(3);
      chk("R1 mode", int'(mode_o), 0);
      chk("R1 valid", int'(d_valid), 0);
      chk("R1 busy", int'({busy_half, busy_full}), 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 R10 R12: stream from index 8
      start(1, 8, 0);
      chk("R12 stream accepted", int'(mode_o), 1);
      start(2, 0, 1);
      chk("R12 start ignored while active", int'(mode_o), 1);
      exp_q.push_back(mk(8, 24, 0, 0, 0));
      evt(1, 0); drain("R2");
      chk("R6 busy half set", int'(busy_half), 1);
      ack(1, 0);
      chk("R6 ack clears half", int'(busy_half), 0);
      exp_q.push_back(mk(32, 32, 0, 1, 1));
      evt(0, 1); drain("R2");
      ack(0, 1);
      exp_q.push_back(mk(0, 32, 0, 0, 2));
      evt(1, 0); drain("R10");
      ack(1, 0);
      stop();
      chk("R12 stop to idle", int'(mode_o), 0);

      // R3 R4 R5: block capture of 10 groups from 16
      start(2, 16, 10);
      exp_q.push_back(mk(16, 16, 0, 0, 0));
      evt(1, 0); drain("R3");
      ack(1, 0);
      exp_q.push_back(mk(32, 24, 1, 1, 1));
      evt(0, 1); drain("R4");
      chk("R5 block closes to idle", int'(mode_o), 0);

      // R9 R5: triggered with rearm, lone half past midpoint
      auto_rearm = 1;
      start(3, 40, 3);
      exp_q.push_back(mk(40, 12, 1, 1, 0));
      evt(1, 0); drain("R9");
      chk("R5 rearm pending", int'(mode_o), 4);
      auto_rearm = 0;
      stop();

      // R8: both events, start past midpoint
      start(1, 36, 0);
      exp_q.push_back(mk(36, 28, 0, 1, 0));
      exp_q.push_back(mk(0, 32, 0, 0, 1));
      evt(1, 1); drain("R8 past mid");
      ack(1, 1);
      stop();

      // R8: both events, start below midpoint
      start(1, 4, 0);
      exp_q.push_back(mk(4, 28, 0, 0, 0));
      exp_q.push_back(mk(32, 32, 0, 1, 1));
      evt(1, 1); drain("R8 below mid");
      stop();

      // R6: overrun of an unacknowledged half
      start(1, 0, 0);
      exp_q.push_back(mk(0, 32, 0, 0, 0));
      evt(1, 0); drain("R6");
      exp_q.push_back(mk(32, 32, 0, 1, 1));
      evt(0, 1); drain("R6");
      evt(1, 0); cyc(4);
      chk("R6 shutdown", int'(mode_o), 5);
      chk("R6 no chunk in shutdown", int'(d_valid), 0);
      stop();
      chk("R6 stop leaves shutdown", int'(mode_o), 0);

      // R7: empty span produces nothing, start still advances
      start(1, 32, 0);
      evt(1, 0); cyc(4);
      chk("R7 no chunk for empty span", int'(d_valid), 0);
      exp_q.push_back(mk(32, 32, 0, 1, 0));
      evt(0, 1); drain("R7");
      stop();

      // R11: stalled consumer, events latched
      start(1, 0, 0);
      @(negedge clk); d_ready = 0;
      evt(1, 0);
      cyc(2);
      evt(0, 1);
      cyc(2);
      chk("R11 valid held", int'(d_valid), 1);
      chk("R11 start held", int'(d_start), 0);
      chk("R11 seq held", int'(d_seq), 0);
      exp_q.push_back(mk(0, 32, 0, 0, 0));
      exp_q.push_back(mk(32, 32, 0, 1, 1));
      @(negedge clk); d_ready = 1;
      drain("R11");
      stop();

      cyc(3);
      finish_run();
   end
endmodule